// File: doc/BRIEF.md
# Timestamp Bunch Packetizer

This block gathers fixed-width event records (96 bits, low-order timestamp and counter fields only) into bunches and streams every bunch out as 16-bit words toward a packet transmit engine. Alongside each record the producer presents the full-width values (160 bits) that belong to that record. When a bunch closes, the full-width value of its last accepted record is appended as a 10-word trailer. The receiver uses the trailer to rebuild the high-order bits of every record in the bunch.

A bunch closes when it reaches `MAX_EVT` records, or when `TMO_CYC` cycles have passed since the timer last restarted, whichever comes first. Turning a 96-bit record into six output words takes six cycles. Two bunch buffers therefore take turns: one fills while the other drains. A record that arrives while neither buffer can take it is discarded and counted.

The output is a valid/ready stream. The block holds `out_valid` together with the data and `last` marker until `out_ready` is seen high at a clock edge. `out_ready` may be held low for any number of cycles. The input has no back-pressure: a record is offered for one cycle on `evt_valid` and is either stored or dropped.

Top module: `bunch_packetizer`

## Requirements
- R1: After reset, `out_valid` is 0 and `drop_count` is 0.
- R2: A bunch closes on the clock edge that stores its `MAX_EVT`-th record, and `out_valid` is high right after that edge. Its records leave in arrival order. Each record is sent as `REC_W/OUT_W` words, most significant word first (word 0 = bits 95:80).
- R3: The records of a bunch are followed by `FULL_W/OUT_W` trailer words, most significant first (word 0 = bits 159:144). These words carry the full-width value presented with the bunch's last accepted record. `out_last` is high only on the final trailer word.
- R4: A bunch holding 1 to `MAX_EVT-1` records closes on the `TMO_CYC`-th clock edge after the timer last restarted.
- R5: When the timer expires with no record collected, nothing is sent and the timer restarts.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: While one closed bunch waits or drains, the other buffer accepts new records without loss.
- R8: A record offered while both buffers hold closed bunches is discarded. It never appears on the output, and `drop_count` rises by exactly one for it.
- R9: Bunches leave in the order in which they closed.
- R10: The timer restarts on every bunch close, whether the close came from the count or from the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A record is offered this cycle |
| evt_rec | input | 96 | Per-event record (low-order fields) |
| evt_full | input | 160 | Full-width timestamp and counters belonging to the record |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Transmit engine accepts the word |
| out_data | output | 16 | Output word |
| out_last | output | 1 | Final trailer word of a bunch |
| drop_count | output | 16 | Wrapping count of discarded records |

## Verification
A count close raises `out_valid` right after the edge that stores the closing record. A timeout close raises it right after the `TMO_CYC`-th edge following the previous close. The bench checks the timeout case one cycle before and one cycle after that edge. Each output word leaves on the edge where `out_valid` and `out_ready` are both high, and `drop_count` moves on the edge that sees a discarded record. All outputs are sampled one nanosecond before a rising edge, with the inputs already settled. Every output word is compared, in order, against a queue the bench builds from the records it offers. The bench also checks the word count of each bunch and the drop count at fixed points between bursts.

// File: rtl/bunch_pkg.sv
package bunch_pkg;
  typedef enum logic {PH_REC = 1'b0, PH_TRL = 1'b1} drain_ph_e;

  function automatic int words_of(int bits, int w);
    return (bits + w - 1) / w;
  endfunction
endpackage

// File: rtl/bunch_fill_ctl.sv
module bunch_fill_ctl #(
  parameter int MAX_EVT = 20,
  parameter int DEPTH   = 40,
  parameter int TMO_CYC = 20000000,
  parameter int DROP_W  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int TMR_W  = $clog2(TMO_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              rel,
  input  logic              rd_sel,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              close,
  output logic [CNT_W-1:0]  close_cnt,
  output logic [1:0]        full,
  output logic [DROP_W-1:0] drop_count
);
  logic             wsel;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic             writable, acc, tmo;
  logic [1:0]       set_v, clr_v;

  assign writable  = !full[wsel];
  assign acc       = evt_valid && writable;
  assign tmo       = (tmr == TMR_W'(TMO_CYC - 1));
  // close on reaching the bunch size, or on expiry with something collected
  assign close     = (acc && cnt == CNT_W'(MAX_EVT - 1)) ||
                     (tmo && (cnt != '0 || acc));
  assign close_cnt = cnt + CNT_W'(acc);
  assign set_v     = {close && wsel, close && !wsel};
  assign clr_v     = {rel && rd_sel, rel && !rd_sel};

  assign wr_en   = acc;
  assign wr_sel  = wsel;
  assign wr_addr = cnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel       <= 1'b0;
      cnt        <= '0;
      tmr        <= '0;
      full       <= '0;
      drop_count <= '0;
    end else begin
      full <= (full & ~clr_v) | set_v;
      if (close) begin
        wsel <= ~wsel;
        cnt  <= '0;
      end else if (acc) begin
        cnt <= cnt + CNT_W'(1);
      end
      tmr <= (close || tmo) ? '0 : tmr + TMR_W'(1);
      if (evt_valid && !writable) drop_count <= drop_count + DROP_W'(1);
    end
  end
endmodule

// File: rtl/bunch_store.sv
module bunch_store #(
  parameter int REC_W  = 96,
  parameter int FULL_W = 160,
  parameter int DEPTH  = 40,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REC_W-1:0]  wr_rec,
  input  logic [FULL_W-1:0] wr_full,
  input  logic              close,
  input  logic [CNT_W-1:0]  close_cnt,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REC_W-1:0]  rd_rec,
  output logic [FULL_W-1:0] rd_trl,
  output logic [CNT_W-1:0]  rd_cnt
);
  logic [REC_W-1:0]  rec_b [2];
  logic [FULL_W-1:0] trl_b [2];
  logic [CNT_W-1:0]  cnt_b [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [REC_W-1:0]  mem [DEPTH];
    logic [FULL_W-1:0] trl_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_sel == 1'(b)) begin
        mem[wr_addr] <= wr_rec;
        trl_q        <= wr_full;
      end
      if (close && wr_sel == 1'(b)) cnt_q <= close_cnt;
    end

    assign rec_b[b] = mem[rd_addr];
    assign trl_b[b] = trl_q;
    assign cnt_b[b] = cnt_q;
  end

  assign rd_rec = rec_b[rd_sel];
  assign rd_trl = trl_b[rd_sel];
  assign rd_cnt = cnt_b[rd_sel];
endmodule

// File: rtl/bunch_drain.sv
module bunch_drain import bunch_pkg::*; #(
  parameter int REC_W  = 96,
  parameter int FULL_W = 160,
  parameter int OUT_W  = 16,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        full,
  input  logic [CNT_W-1:0]  bunch_cnt,
  input  logic [REC_W-1:0]  rec,
  input  logic [FULL_W-1:0] trl,
  input  logic              out_ready,
  output logic              rd_sel,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rel,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last
);
  localparam int REC_WORDS = words_of(REC_W, OUT_W);
  localparam int TRL_WORDS = words_of(FULL_W, OUT_W);
  localparam int IDX_W     = $clog2(TRL_WORDS > REC_WORDS ? TRL_WORDS : REC_WORDS);

  drain_ph_e        ph;
  logic [IDX_W-1:0] widx;
  logic             fire, rec_end, trl_end, bunch_rec_end;

  assign out_valid     = full[rd_sel];
  assign fire          = out_valid && out_ready;
  assign rec_end       = (widx == IDX_W'(REC_WORDS - 1));
  assign trl_end       = (widx == IDX_W'(TRL_WORDS - 1));
  assign bunch_rec_end = (CNT_W'(rd_addr) == bunch_cnt - CNT_W'(1));
  assign rel           = fire && ph == PH_TRL && trl_end;
  assign out_last      = out_valid && ph == PH_TRL && trl_end;

  always_comb begin
    if (ph == PH_REC) out_data = rec[(REC_WORDS - 1 - int'(widx)) * OUT_W +: OUT_W];
    else              out_data = trl[(TRL_WORDS - 1 - int'(widx)) * OUT_W +: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_REC;
      widx    <= '0;
      rd_addr <= '0;
      rd_sel  <= 1'b0;
    end else if (fire) begin
      if (ph == PH_REC) begin
        if (rec_end) begin
          widx <= '0;
          if (bunch_rec_end) begin
            ph      <= PH_TRL;
            rd_addr <= '0;
          end else begin
            rd_addr <= rd_addr + ADDR_W'(1);
          end
        end else begin
          widx <= widx + IDX_W'(1);
        end
      end else begin
        if (trl_end) begin
          widx   <= '0;
          ph     <= PH_REC;
          rd_sel <= ~rd_sel;
        end else begin
          widx <= widx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bunch_packetizer.sv
module bunch_packetizer #(
  parameter int REC_W   = 96,
  parameter int FULL_W  = 160,
  parameter int OUT_W   = 16,
  parameter int MAX_EVT = 20,
  parameter int DEPTH   = 40,
  parameter int TMO_CYC = 20000000,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [REC_W-1:0]  evt_rec,
  input  logic [FULL_W-1:0] evt_full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last,
  output logic [DROP_W-1:0] drop_count
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  logic              wr_en, wr_sel, close, rel, rd_sel;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0]  close_cnt, rd_cnt;
  logic [1:0]        full;
  logic [REC_W-1:0]  rd_rec;
  logic [FULL_W-1:0] rd_trl;

  bunch_fill_ctl #(
    .MAX_EVT(MAX_EVT), .DEPTH(DEPTH), .TMO_CYC(TMO_CYC), .DROP_W(DROP_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .rel(rel), .rd_sel(rd_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .close(close),
    .close_cnt(close_cnt), .full(full), .drop_count(drop_count)
  );

  bunch_store #(
    .REC_W(REC_W), .FULL_W(FULL_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_rec(evt_rec), .wr_full(evt_full), .close(close), .close_cnt(close_cnt),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_rec(rd_rec), .rd_trl(rd_trl),
    .rd_cnt(rd_cnt)
  );

  bunch_drain #(
    .REC_W(REC_W), .FULL_W(FULL_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .full(full), .bunch_cnt(rd_cnt), .rec(rd_rec),
    .trl(rd_trl), .out_ready(out_ready), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rel(rel), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/bunch_packetizer_chk.sv
module bunch_packetizer_chk #(
  parameter int REC_W   = 96,
  parameter int FULL_W  = 160,
  parameter int OUT_W   = 16,
  parameter int MAX_EVT = 20,
  parameter int DROP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_last,
  input logic [DROP_W-1:0] drop_count
);
  localparam int REC_WORDS = (REC_W + OUT_W - 1) / OUT_W;
  localparam int TRL_WORDS = (FULL_W + OUT_W - 1) / OUT_W;
  localparam int MAX_WORDS = MAX_EVT * REC_WORDS + TRL_WORDS;

  logic        fire;
  logic [15:0] wc;
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                wc <= '0;
    else if (fire && out_last) wc <= '0;
    else if (fire)             wc <= wc + 16'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && drop_count == '0));

  // R2
  bunch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> int'(wc) < MAX_WORDS);

  // R3
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |-> (int'(wc) + 1 > TRL_WORDS &&
                            (int'(wc) + 1 - TRL_WORDS) % REC_WORDS == 0));

  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> drop_count == $past(drop_count) + DROP_W'(1));
endmodule

bind bunch_packetizer bunch_packetizer_chk #(
  .REC_W(REC_W), .FULL_W(FULL_W), .OUT_W(OUT_W), .MAX_EVT(MAX_EVT), .DROP_W(DROP_W)
) u_chk (.*);

// File: tb/tb_bunch_packetizer.sv
module tb_bunch_packetizer;
  localparam int TMO   = 1000;
  localparam int MAXE  = 20;
  localparam int NROWS = 6;
  // row: [15:8] expected word count, [7] random out_ready, [6:0] records
  localparam logic [15:0] ROWS [NROWS] = '{
    {8'd130, 1'b0, 7'd20}, {8'd130, 1'b1, 7'd20}, {8'd40,  1'b0, 7'd5},
    {8'd16,  1'b1, 7'd1},  {8'd124, 1'b1, 7'd19}, {8'd82,  1'b0, 7'd12}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_valid = 1'b0;
  logic [95:0]  evt_rec = '0;
  logic [159:0] evt_full = '0;
  logic         out_valid, out_ready, out_last;
  logic [15:0]  out_data, drop_count;

  int tests = 0, fails = 0, rx_words = 0, ready_mode = 0;
  bit seen_valid = 0;
  logic [7:0]  lfsr = 8'h5A;
  logic [19:0] exp_q [$];

  always #5 clk = ~clk;

  bunch_packetizer #(.TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_rec(evt_rec),
    .evt_full(evt_full), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .drop_count(drop_count)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = lfsr[0];
      default: out_ready = 1'b0;
    endcase
  end

  function automatic logic [95:0] mk_rec(int b, int i);
    return {16'hB000 + 16'(b), 16'(i), 32'hC0DE0000 + 32'(b * 64 + i),
            32'h13579BDF ^ 32'(b * 97 + i)};
  endfunction

  function automatic logic [159:0] mk_full(int b, int i);
    return {32'(b), 32'(i), 32'hF00D0000 + 32'(i), 64'(b * 100000 + i)};
  endfunction

  task automatic check(int req, logic [31:0] act, logic [31:0] expv, string what);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // output monitor: 1 ns before each rising edge; records are R2, trailers R3, order R9
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (out_valid) seen_valid = 1;
      if (rst_n && out_valid && out_ready) begin
        rx_words++;
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R9 unexpected word: actual %0h expected none", out_data);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          check(int'(e[19:17]), {15'd0, out_last, out_data}, {15'd0, e[16], e[15:0]},
                "word/last");
        end
      end
    end
  end

  task automatic push_rec(int b, int i);
    logic [95:0] r;
    r = mk_rec(b, i);
    for (int w = 0; w < 6; w++) exp_q.push_back({3'd2, 1'b0, r[(5 - w) * 16 +: 16]});
  endtask

  task automatic push_trl(int b, int i);
    logic [159:0] f;
    f = mk_full(b, i);
    for (int w = 0; w < 10; w++) exp_q.push_back({3'd3, w == 9, f[(9 - w) * 16 +: 16]});
  endtask

  task automatic send_burst(int b, int n, bit expect_kept);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_valid = 1'b1;
      evt_rec   = mk_rec(b, i);
      evt_full  = mk_full(b, i);
      if (expect_kept) push_rec(b, i);
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_empty();
    for (int k = 0; k < 4000 && (exp_q.size() != 0); k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, {31'd0, out_valid}, 32'd0, "out_valid after reset");
    check(1, {16'd0, drop_count}, 32'd0, "drop_count after reset");

    // table of bunches: R2 count closes, R4 timeout closes, R6 stalls
    for (int r = 0; r < NROWS; r++) begin
      int n;
      n = int'(ROWS[r][6:0]);
      ready_mode = ROWS[r][7] ? 1 : 0;
      rx_words = 0;
      send_burst(r, n, 1'b1);
      push_trl(r, n - 1);
      wait_empty();
      check(n == MAXE ? 2 : 4, rx_words, {24'd0, ROWS[r][15:8]}, "bunch word count");
    end

    // R10: timer restarts on a count close; the next single record closes by timeout
    ready_mode = 0;
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      evt_valid = 1'b1;
      evt_rec   = mk_rec(40 + i / 20, i);
      evt_full  = mk_full(40 + i / 20, i);
      push_rec(40 + i / 20, i);
      if (i == 19) push_trl(40, 19);
    end
    push_trl(41, 20);
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (TMO - 2) @(negedge clk);
    check(10, {31'd0, out_valid}, 32'd0, "no close before timeout edge");
    @(negedge clk);
    check(4, {31'd0, out_valid}, 32'd1, "timeout close after count close");
    wait_empty();

    // R7 and R8: output stalled, two bunches fill, the rest is dropped
    ready_mode = 2;
    d0 = drop_count;
    rx_words = 0;
    send_burst(50, 20, 1'b1);
    push_trl(50, 19);
    send_burst(51, 20, 1'b1);
    push_trl(51, 19);
    check(7, {16'd0, drop_count}, {16'd0, d0}, "second buffer fills with no drop");
    send_burst(52, 3, 1'b0);
    check(8, {16'd0, drop_count}, {16'd0, d0 + 16'd3}, "drop count while both busy");
    ready_mode = 0;
    wait_empty();
    check(8, rx_words, 32'd260, "dropped records absent from output");

    // R5: an empty timeout sends nothing
    seen_valid = 0;
    repeat (TMO * 5 / 2) @(negedge clk);
    check(5, {31'd0, seen_valid}, 32'd0, "no output on empty timeouts");
    rx_words = 0;
    send_burst(60, 1, 1'b1);
    push_trl(60, 0);
    wait_empty();
    check(4, rx_words, 32'd16, "single record after idle closes by timeout");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule